// File: doc/BRIEF.md
# Processing-in-Memory Instruction Unroller

This block sits between a host instruction queue and a bank of per-channel memory controllers in a processing-in-memory subsystem. It takes one decoded instruction at a time and expands it into a stream of column requests. The 32-bit channel mask picks the channels that take part. For each picked channel, a number of consecutive columns of the given row is emitted. That number comes from the opcode and the operand size. Every request moves one 256-bit unit, which is sixteen half-precision values. The requests leave on a valid/ready interface that carries the channel, bank, row, column, operation and register index.

Some instructions read results back into a host register, and some are barriers. These keep the block from taking new work until the downstream controller pulses an execution-complete input. The end-of-compute instruction stops the block for good and raises a done flag. A write to all banks must name exactly one channel. Any other mask is refused with a sticky error.

Top module: `pim_unroller`

## Requirements
- R1: After reset, instReady is 1, and reqValid, errFlag and doneFlag are 0.
- R2: Requests go only to channels whose bit is set in instMask, and the channels are visited in ascending index order. All of one channel's requests go out before the next channel starts.
- R3: Within a channel, the columns run 0, 1, 2, ... in increasing order. Sized opcodes emit instSize columns, with a size of 0 treated as 1. The sized opcodes are 2 (write global), 7 (copy to global), 8 (copy from global), 9 (single-bank MAC), 10 (all-bank MAC), 12 (element-wise multiply) and 13 (element-wise add). Every other issuing opcode emits one column. Bank, row, opcode and register index are copied from the instruction.
- R4: While reqValid is 1 and reqReady is 0, reqValid stays 1 and every request field stays unchanged.
- R5: Opcode 1 (write all banks) with a mask whose bit count is not exactly one issues no request. It sets errFlag, which stays 1 until reset, and the block is ready again in the next cycle.
- R6: Opcodes 4 (read accumulators), 5 (read activations), 14 (barrier) and 15 (end of compute) hold the block. After their requests, instReady stays 0 until execDone is pulsed. Opcodes 14 and 15 issue no requests. execDone has no effect while the block is idle.
- R7: Once an end-of-compute instruction has completed, doneFlag is 1, and instReady and reqValid stay 0 until reset.
- R8: instReady is 0 while an instruction is being unrolled. Only one instruction is in flight.
- R9: An issuing instruction with an all-zero mask emits no request. A non-holding opcode of this kind leaves the block ready in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Block accepts an instruction |
| instOp | input | 4 | Opcode |
| instMask | input | 32 | Target channel mask |
| instSize | input | COL_W | Operand size in columns |
| instBank | input | BANK_W | Bank field |
| instRow | input | ROW_W | Row field |
| instReg | input | REG_W | Host register index |
| reqValid | output | 1 | Column request present |
| reqReady | input | 1 | Downstream takes the request |
| reqChan | output | 5 | Target channel |
| reqBank | output | BANK_W | Target bank |
| reqRow | output | ROW_W | Target row |
| reqCol | output | COL_W | Target column |
| reqOp | output | 4 | Operation |
| reqReg | output | REG_W | Host register index |
| execDone | input | 1 | Held instruction has executed |
| errFlag | output | 1 | Sticky illegal-mask flag |
| doneFlag | output | 1 | End of compute reached |

## Verification
Table-driven instructions exercise the unroller with several kinds of mask:
- a single low channel;
- the two extreme channels, which exposes wrong ordering or a missing top bit;
- a dense nibble and a sparse pair;
- the full mask;
- an alternating mask with the largest operand size, which shows whether the column counter wraps at the right limit per channel.

The table mixes sized and unsized opcodes with size values of zero and non-zero, which separates the opcode-driven factor from the size-driven one. The table also uses three ready patterns, so stalls land on first, middle and last beats. Directed cases then cover the refused mask, holding reads, barriers, an idle execDone pulse and end of compute.

// File: rtl/pim_unroll_pkg.sv
package pim_unroll_pkg;

  localparam int NUM_CHAN = 32;
  localparam int CHAN_W   = $clog2(NUM_CHAN);

  typedef enum logic [3:0] {
    OP_WR_ONE      = 4'd0,
    OP_WR_ALL      = 4'd1,
    OP_WR_GLOBAL   = 4'd2,
    OP_WR_BIAS     = 4'd3,
    OP_RD_ACC      = 4'd4,
    OP_RD_ACT      = 4'd5,
    OP_RD_ONE      = 4'd6,
    OP_CP_TO_GLB   = 4'd7,
    OP_CP_FROM_GLB = 4'd8,
    OP_MAC_ONE     = 4'd9,
    OP_MAC_ALL     = 4'd10,
    OP_ACT         = 4'd11,
    OP_EW_MUL      = 4'd12,
    OP_EW_ADD      = 4'd13,
    OP_BARRIER     = 4'd14,
    OP_END         = 4'd15
  } pimOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advCol;
    logic nextChan;
  } dpCtrl_t;

  // opcode whose column count follows the operand size
  function automatic logic isSized(input logic [3:0] op);
    case (op)
      OP_WR_GLOBAL, OP_CP_TO_GLB, OP_CP_FROM_GLB, OP_MAC_ONE,
      OP_MAC_ALL, OP_EW_MUL, OP_EW_ADD: isSized = 1'b1;
      default:                          isSized = 1'b0;
    endcase
  endfunction

  // opcode that must wait for downstream execution
  function automatic logic isHold(input logic [3:0] op);
    case (op)
      OP_RD_ACC, OP_RD_ACT, OP_BARRIER, OP_END: isHold = 1'b1;
      default:                                  isHold = 1'b0;
    endcase
  endfunction

  // opcode that issues no column requests at all
  function automatic logic isFence(input logic [3:0] op);
    isFence = (op == OP_BARRIER) || (op == OP_END);
  endfunction

endpackage

// File: rtl/pim_unroll_dp.sv
module pim_unroll_dp
  import pim_unroll_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 6,
  parameter int REG_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpCtrl_t             dpCtrl,
  input  logic [3:0]          instOp,
  input  logic [NUM_CHAN-1:0] instMask,
  input  logic [COL_W-1:0]    instSize,
  input  logic [BANK_W-1:0]   instBank,
  input  logic [ROW_W-1:0]    instRow,
  input  logic [REG_W-1:0]    instReg,
  output logic [CHAN_W-1:0]   reqChan,
  output logic [BANK_W-1:0]   reqBank,
  output logic [ROW_W-1:0]    reqRow,
  output logic [COL_W-1:0]    reqCol,
  output logic [3:0]          reqOp,
  output logic [REG_W-1:0]    reqReg,
  output logic                lastCol,
  output logic                moreChan
);

  localparam logic [COL_W-1:0] ONE_COL = COL_W'(1);

  logic [NUM_CHAN-1:0] pendMask;
  logic [COL_W-1:0]    colCnt;
  logic [COL_W-1:0]    colLast;
  logic [COL_W-1:0]    sizeEff;
  logic [COL_W-1:0]    colLastNext;
  logic [NUM_CHAN-1:0] chanBit;

  function automatic logic [CHAN_W-1:0] lowestSet(input logic [NUM_CHAN-1:0] m);
    lowestSet = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (m[i]) lowestSet = i[CHAN_W-1:0];
    end
  endfunction

  always_comb begin
    sizeEff     = (instSize == '0) ? ONE_COL : instSize;
    colLastNext = isSized(instOp) ? (sizeEff - ONE_COL) : '0;
  end

  assign reqChan  = lowestSet(pendMask);
  assign chanBit  = {{(NUM_CHAN-1){1'b0}}, 1'b1} << reqChan;
  assign reqCol   = colCnt;
  assign lastCol  = (colCnt == colLast);
  assign moreChan = ($countones(pendMask) > 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendMask <= '0;
      colCnt   <= '0;
      colLast  <= '0;
      reqBank  <= '0;
      reqRow   <= '0;
      reqOp    <= '0;
      reqReg   <= '0;
    end else if (dpCtrl.load) begin
      pendMask <= instMask;
      colCnt   <= '0;
      colLast  <= colLastNext;
      reqBank  <= instBank;
      reqRow   <= instRow;
      reqOp    <= instOp;
      reqReg   <= instReg;
    end else if (dpCtrl.nextChan) begin
      pendMask <= pendMask & ~chanBit;
      colCnt   <= '0;
    end else if (dpCtrl.advCol) begin
      colCnt   <= colCnt + ONE_COL;
    end
  end

endmodule

// File: rtl/pim_unroll_ctrl.sv
module pim_unroll_ctrl
  import pim_unroll_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instValid,
  input  logic [3:0]          instOp,
  input  logic [NUM_CHAN-1:0] instMask,
  input  logic                reqReady,
  input  logic                execDone,
  input  logic                lastCol,
  input  logic                moreChan,
  output logic                instReady,
  output logic                reqValid,
  output logic                errFlag,
  output logic                doneFlag,
  output dpCtrl_t             dpCtrl
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e state, stateNext;
  logic   holdR, endR;
  logic   accept, badMask, setErr;

  assign accept  = instValid && (state == S_IDLE);
  assign badMask = (instOp == OP_WR_ALL) && ($countones(instMask) != 1);

  always_comb begin
    stateNext = state;
    dpCtrl    = '0;
    setErr    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          dpCtrl.load = 1'b1;
          if (badMask)                  setErr    = 1'b1;
          else if (isFence(instOp))     stateNext = S_WAIT;
          else if (instMask == '0)      stateNext = isHold(instOp) ? S_WAIT : S_IDLE;
          else                          stateNext = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (reqReady) begin
          if (!lastCol)      dpCtrl.advCol = 1'b1;
          else if (moreChan) dpCtrl.nextChan = 1'b1;
          else               stateNext = holdR ? S_WAIT : S_IDLE;
        end
      end
      S_WAIT: begin
        if (execDone) stateNext = endR ? S_DONE : S_IDLE;
      end
      S_DONE: stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      holdR   <= 1'b0;
      endR    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        holdR <= isHold(instOp);
        endR  <= (instOp == OP_END);
      end
      if (setErr) errFlag <= 1'b1;
    end
  end

  assign instReady = (state == S_IDLE);
  assign reqValid  = (state == S_ISSUE);
  assign doneFlag  = (state == S_DONE);

  // R5: the error flag never clears on its own
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

  // R7: end of compute is terminal
  p_done_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    doneFlag |=> doneFlag && !instReady && !reqValid);

  // R6: a held instruction releases only on execDone
  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !execDone) |=> !instReady);

endmodule

// File: rtl/pim_unroller.sv
module pim_unroller
  import pim_unroll_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 6,
  parameter int REG_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instValid,
  output logic                instReady,
  input  logic [3:0]          instOp,
  input  logic [NUM_CHAN-1:0] instMask,
  input  logic [COL_W-1:0]    instSize,
  input  logic [BANK_W-1:0]   instBank,
  input  logic [ROW_W-1:0]    instRow,
  input  logic [REG_W-1:0]    instReg,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [CHAN_W-1:0]   reqChan,
  output logic [BANK_W-1:0]   reqBank,
  output logic [ROW_W-1:0]    reqRow,
  output logic [COL_W-1:0]    reqCol,
  output logic [3:0]          reqOp,
  output logic [REG_W-1:0]    reqReg,
  input  logic                execDone,
  output logic                errFlag,
  output logic                doneFlag
);

  dpCtrl_t dpCtrl;
  logic    lastCol, moreChan;

  pim_unroll_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .instValid (instValid),
    .instOp    (instOp),
    .instMask  (instMask),
    .reqReady  (reqReady),
    .execDone  (execDone),
    .lastCol   (lastCol),
    .moreChan  (moreChan),
    .instReady (instReady),
    .reqValid  (reqValid),
    .errFlag   (errFlag),
    .doneFlag  (doneFlag),
    .dpCtrl    (dpCtrl)
  );

  pim_unroll_dp #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dpCtrl   (dpCtrl),
    .instOp   (instOp),
    .instMask (instMask),
    .instSize (instSize),
    .instBank (instBank),
    .instRow  (instRow),
    .instReg  (instReg),
    .reqChan  (reqChan),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqOp    (reqOp),
    .reqReg   (reqReg),
    .lastCol  (lastCol),
    .moreChan (moreChan)
  );

  // R4: a stalled request holds still
  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |=> reqValid && $stable(reqChan) && $stable(reqCol)
      && $stable(reqRow) && $stable(reqBank) && $stable(reqOp) && $stable(reqReg));

  // R8: no new instruction while requests are outstanding
  p_busy_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> !instReady);

  // R2: channel index never decreases within one burst
  p_chan_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && $past(reqValid) && $past(reqReady)) |-> (reqChan >= $past(reqChan)));

endmodule

// File: tb/pim_unroller_bench.sv
`timescale 1ns/1ps
module pim_unroller_bench;

  localparam int BANK_W = 4;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 6;
  localparam int REG_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instValid = 1'b0;
  logic [3:0] instOp = '0;
  logic [31:0] instMask = '0;
  logic [COL_W-1:0] instSize = '0;
  logic [BANK_W-1:0] instBank = '0;
  logic [ROW_W-1:0] instRow = '0;
  logic [REG_W-1:0] instReg = '0;
  logic reqReady = 1'b1;
  logic execDone = 1'b0;
  logic instReady, reqValid, errFlag, doneFlag;
  logic [4:0] reqChan;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0] reqRow;
  logic [COL_W-1:0] reqCol;
  logic [3:0] reqOp;
  logic [REG_W-1:0] reqReg;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pim_unroller #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .REG_W(REG_W)) u_pim_unroller (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instReady(instReady),
    .instOp(instOp), .instMask(instMask), .instSize(instSize), .instBank(instBank),
    .instRow(instRow), .instReg(instReg), .reqValid(reqValid), .reqReady(reqReady),
    .reqChan(reqChan), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqOp(reqOp), .reqReg(reqReg), .execDone(execDone), .errFlag(errFlag),
    .doneFlag(doneFlag)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] mask;
    logic [5:0]  size;
    logic [1:0]  pat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  32'h0000_0001, 6'd5,  2'd0},
    '{4'd10, 32'h8000_0001, 6'd3,  2'd1},
    '{4'd2,  32'h0000_F000, 6'd0,  2'd0},
    '{4'd12, 32'h0001_0100, 6'd4,  2'd2},
    '{4'd11, 32'hFFFF_FFFF, 6'd7,  2'd1},
    '{4'd7,  32'h5555_5555, 6'd63, 2'd0},
    '{4'd1,  32'h0000_0040, 6'd2,  2'd2},
    '{4'd13, 32'h0000_0000, 6'd3,  2'd0}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int colsFor(input logic [3:0] op, input logic [5:0] size);
    if (op == 4'd2 || op == 4'd7 || op == 4'd8 || op == 4'd9 ||
        op == 4'd10 || op == 4'd12 || op == 4'd13)
      return (size == 0) ? 1 : int'(size);
    return 1;
  endfunction

  function automatic int nextSet(input logic [31:0] m, input int from);
    for (int i = from; i < 32; i++) if (m[i]) return i;
    return 32;
  endfunction

  function automatic logic readyFor(input logic [1:0] pat, input int cyc);
    case (pat)
      2'd1:    return cyc[0];
      2'd2:    return (cyc % 3) == 2;
      default: return 1'b1;
    endcase
  endfunction

  // present one instruction, then follow and check its request stream
  task automatic runInst(input logic [3:0] op, input logic [31:0] mask, input logic [5:0] size,
                         input logic [1:0] pat, input int tag, output int beats);
    int expChan, expCol, eff, cyc, expBeats;
    logic stalled;
    logic [4:0] sChan;
    logic [COL_W-1:0] sCol;
    logic illegal;
    illegal = (op == 4'd1) && ($countones(mask) != 1);
    eff = colsFor(op, size);
    expBeats = (illegal || op == 4'd14 || op == 4'd15) ? 0 : $countones(mask) * eff;
    @(negedge clk);
    instOp = op; instMask = mask; instSize = size;
    instBank = BANK_W'(tag); instRow = ROW_W'(100 + tag); instReg = REG_W'(tag + 3);
    instValid = 1'b1;
    while (!instReady) @(negedge clk);
    @(negedge clk);
    instValid = 1'b0;
    beats = 0; cyc = 0; stalled = 1'b0; sChan = '0; sCol = '0;
    expChan = nextSet(mask, 0); expCol = 0;
    reqReady = readyFor(pat, cyc);
    while (reqValid) begin
      if (stalled)  // R4
        chk(reqChan == sChan && reqCol == sCol, "R4 stall stability", {reqChan, reqCol}, {sChan, sCol});
      if (reqReady) begin
        // R2 channel order, R3 columns and carried fields
        chk(int'(reqChan) == expChan, "R2 channel", reqChan, expChan);
        chk(int'(reqCol) == expCol, "R3 column", reqCol, expCol);
        chk(reqBank == BANK_W'(tag) && reqRow == ROW_W'(100 + tag) && reqOp == op
            && reqReg == REG_W'(tag + 3), "R3 fields", {reqBank, reqRow, reqOp, reqReg},
            {BANK_W'(tag), ROW_W'(100 + tag), op, REG_W'(tag + 3)});
        chk(!instReady, "R8 busy", instReady, 0);
        beats++; stalled = 1'b0;
        expCol++;
        if (expCol == eff) begin expCol = 0; expChan = nextSet(mask, expChan + 1); end
      end else begin
        stalled = 1'b1; sChan = reqChan; sCol = reqCol;
      end
      @(negedge clk);
      cyc++;
      reqReady = readyFor(pat, cyc);
    end
    reqReady = 1'b1;
    chk(beats == expBeats, "R3 beat count", beats, expBeats);
  endtask

  task automatic pulseExec();
    @(negedge clk); execDone = 1'b1;
    @(negedge clk); execDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int beats;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instReady && !reqValid && !errFlag && !doneFlag, "R1 reset state",
        {instReady, reqValid, errFlag, doneFlag}, 4'b1000);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      runInst(VECS[v].op, VECS[v].mask, VECS[v].size, VECS[v].pat, v, beats);
      chk(instReady, "R9 ready after non-holding op", instReady, 1);
    end
    chk(!errFlag, "R5 no error on legal ops", errFlag, 0);

    // R9 zero mask: ready right after acceptance
    runInst(4'd9, 32'h0, 6'd4, 2'd0, 9, beats);
    chk(beats == 0 && instReady, "R9 empty mask", {beats[7:0], instReady}, 9'h001);

    // R5 illegal mask on all-bank write
    runInst(4'd1, 32'h0000_0003, 6'd1, 2'd0, 10, beats);
    chk(errFlag, "R5 error raised", errFlag, 1);
    chk(instReady, "R5 ready again", instReady, 1);
    runInst(4'd1, 32'h0, 6'd1, 2'd0, 11, beats);
    chk(errFlag && beats == 0, "R5 zero mask refused", errFlag, 1);
    runInst(4'd6, 32'h0000_0010, 6'd0, 2'd0, 12, beats);
    chk(errFlag, "R5 error sticky", errFlag, 1);

    // R6 holding read
    runInst(4'd4, 32'h0000_0006, 6'd9, 2'd1, 13, beats);
    repeat (4) @(negedge clk);
    chk(!instReady, "R6 held after read", instReady, 0);
    pulseExec();
    chk(instReady, "R6 released by execDone", instReady, 1);

    // R6 execDone ignored while idle
    pulseExec();
    chk(instReady && !reqValid && !doneFlag, "R6 idle execDone ignored",
        {instReady, reqValid, doneFlag}, 3'b100);

    // R6 barrier
    runInst(4'd14, 32'hFFFF_FFFF, 6'd5, 2'd0, 14, beats);
    chk(!instReady && beats == 0, "R6 barrier holds", instReady, 0);
    pulseExec();
    chk(instReady && !doneFlag, "R6 barrier released", {instReady, doneFlag}, 2'b10);

    // R7 end of compute
    runInst(4'd15, 32'h0, 6'd0, 2'd0, 15, beats);
    chk(!instReady && !doneFlag, "R7 end waits", {instReady, doneFlag}, 2'b00);
    pulseExec();
    chk(doneFlag && !instReady, "R7 done raised", {doneFlag, instReady}, 2'b10);
    @(negedge clk);
    instOp = 4'd0; instMask = 32'h1; instValid = 1'b1;
    repeat (5) @(negedge clk);
    chk(doneFlag && !instReady && !reqValid, "R7 stays done",
        {doneFlag, instReady, reqValid}, 3'b100);
    instValid = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule